// File: doc/BRIEF.md
# Telecom Signal Crosspoint with Indirect Source Registers

This block is a register-programmed routing switch between a 16-port line interface and a bit-error-rate tester. Each port has three transmit outputs: a clock, positive data and negative data. Each output takes its value from a source that software picks. The source can be any port's receive signal, one of two reference oscillators, a user clock, one of two auxiliary clocks from the line interface, or the tester's output. A source can also leave the output undriven. The tester's transmit clock, receive clock and receive data inputs are chosen from the same source set.

Software reaches the block through an 8-bit local bus with a chip select, a read strobe, a write strobe and an address. The per-port source registers all sit behind a single three-register window. A bank pointer chooses which port that window addresses. The bus also exposes read-only identity and revision constants, and a control register. The control register drives the line interface's master clock selection, its mode, clock-edge, bit-order and output-enable pins, and the enables of two loss-of-signal LEDs.

Every routed output is modelled as a value plus an output-enable, so an undriven output is simply a low enable. The bus interface is a small state machine with three states. BUS_IDLE accepts an access. It moves to BUS_WR_HOLD when chip select and the write strobe are high, and to BUS_RD_HOLD when chip select and the read strobe are high and the write strobe is low. Both hold states return to BUS_IDLE once no strobe is asserted with chip select. Only BUS_IDLE commits an access, so each strobe assertion performs exactly one access.

Top module: `tsx_crosspoint`

## Requirements
- R1: After reset, every source register holds 0xFF, so all routed output enables are low. The bank pointer and the control register are 0x00, `mclk_oe` is 0, `liu_mode` is 1, `liu_clke`, `liu_bswap`, `liu_oe` and `los_led` are 0, and `bus_rdata` is 0x00.
- R2: The read-only offsets return fixed values: 0x00 returns 0x0D, 0x02 returns 0x00, 0x03 returns 0x01 and 0x04 returns 0x06. Offsets 0x05, 0x06 and 0x07 return the revision parameters, whose defaults are 0x01, 0x02 and 0x03.
- R3: A write to a read-only or unmapped offset changes no register. A read of an unmapped offset (0x01, 0x09, 0x0E, 0x0F, 0x13 and above) returns 0x00.
- R4: An access is committed only in BUS_IDLE, at the first rising edge where chip select and a strobe are both high. A held write strobe writes once, with the data sampled at that first edge. Read data appears on `bus_rdata` at that edge and holds until the next read.
- R5: Offset 0x0A is the bank pointer. With the pointer at n (0x00 to 0x0F), offsets 0x10, 0x11 and 0x12 read and write the clock, positive-data and negative-data source codes of port index n, and leave other ports untouched. With the pointer at 0x10 or above, writes to those offsets are dropped and reads of them return 0x00.
- R6: Source codes 0x00 to 0x0F drive the output from port index `code`. The clock path takes `rx_clk[code]`, the positive-data path takes `rx_pos[code]` and the negative-data path takes `rx_neg[code]`. The enable is high.
- R7: Code 0x10 routes `osc_t1`, 0x11 routes `osc_e1`, 0x12 routes `user_clk`, 0x13 routes `aux_clk_a` and 0x14 routes `aux_clk_b`, each with the enable high.
- R8: Code 0x15 routes `bert_clk_in` on clock paths and `bert_dat_in` on data paths. On negative-data paths it drives a constant 0 with the enable high.
- R9: Codes 0x16 to 0xFF leave the output undriven: the enable is low and the value is 0.
- R10: Offsets 0x0B, 0x0C and 0x0D hold the codes for the tester's transmit clock (clock path), receive clock (clock path) and receive data (positive-data path, port codes take `rx_pos`).
- R11: Control bits 1:0 select the master clock. 00 leaves it undriven, 01 gives `osc_t1`, 10 gives `osc_e1` and 11 gives `user_clk`.
- R12: Control bit 3 selects serial mode, and `liu_mode` is its inverse. `liu_clke` follows bit 5 and `liu_bswap` follows bit 4, but both are 0 while bit 3 is 0. `liu_oe` follows bit 2.
- R13: `los_led[1]` is high only when control bit 7 and `rx_los[15]` are both high. `los_led[0]` is high only when control bit 6 and `rx_los[14]` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rx_clk | input | 16 | Receive clocks of the ports |
| rx_pos | input | 16 | Receive positive data of the ports |
| rx_neg | input | 16 | Receive negative data of the ports |
| rx_los | input | 16 | Loss-of-signal flags of the ports |
| osc_t1 | input | 1 | 1.544 MHz reference oscillator |
| osc_e1 | input | 1 | 2.048 MHz reference oscillator |
| user_clk | input | 1 | User-supplied clock |
| aux_clk_a | input | 1 | First auxiliary clock from the line interface |
| aux_clk_b | input | 1 | Second auxiliary clock from the line interface |
| bert_clk_in | input | 1 | Tester transmit clock output |
| bert_dat_in | input | 1 | Tester transmit data output |
| tx_clk | output | 16 | Routed port transmit clocks |
| tx_clk_oe | output | 16 | Enables of the port transmit clocks |
| tx_pos | output | 16 | Routed port positive data |
| tx_pos_oe | output | 16 | Enables of the port positive data |
| tx_neg | output | 16 | Routed port negative data |
| tx_neg_oe | output | 16 | Enables of the port negative data |
| bert_tclk | output | 1 | Tester transmit clock |
| bert_tclk_oe | output | 1 | Enable of the tester transmit clock |
| bert_rclk | output | 1 | Tester receive clock |
| bert_rclk_oe | output | 1 | Enable of the tester receive clock |
| bert_rdat | output | 1 | Tester receive data |
| bert_rdat_oe | output | 1 | Enable of the tester receive data |
| mclk | output | 1 | Master clock to the line interface |
| mclk_oe | output | 1 | Enable of the master clock |
| liu_mode | output | 1 | Line interface mode pin (1 = parallel) |
| liu_clke | output | 1 | Line interface clock-edge pin |
| liu_bswap | output | 1 | Line interface bit-order pin |
| liu_oe | output | 1 | Line interface output-enable pin |
| los_led | output | 2 | LED drives for ports 15 and 16 |

## Verification
The assertions check several rules on every cycle. Hold states and writes to read-only offsets never change stored registers, and an out-of-range bank pointer blocks indirect writes. An undriven code always lowers the enable, and the tester code drives a low negative-data path. The clock-edge pin is never high in parallel mode, and a lit LED implies its loss flag. Only the bench scenarios can show the value side of routing. That covers each code class on each path under opposite input patterns, indirect readback per port, isolation of untouched ports, the held-strobe single write and the master clock selection.

// File: rtl/tsx_pkg.sv
package tsx_pkg;

    typedef enum logic [1:0] {
        PATH_CLK = 2'd0,
        PATH_POS = 2'd1,
        PATH_NEG = 2'd2
    } path_kind_e;

    typedef enum logic [1:0] {
        BUS_IDLE    = 2'd0,
        BUS_WR_HOLD = 2'd1,
        BUS_RD_HOLD = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic val;
        logic oe;
    } drv_t;

    localparam logic [7:0] OFF_BOARD_ID  = 8'h00;
    localparam logic [7:0] OFF_XID_HI    = 8'h02;
    localparam logic [7:0] OFF_XID_MID   = 8'h03;
    localparam logic [7:0] OFF_XID_LO    = 8'h04;
    localparam logic [7:0] OFF_REV_BOARD = 8'h05;
    localparam logic [7:0] OFF_REV_ASSY  = 8'h06;
    localparam logic [7:0] OFF_REV_FW    = 8'h07;
    localparam logic [7:0] OFF_CTRL      = 8'h08;
    localparam logic [7:0] OFF_BANK      = 8'h0A;
    localparam logic [7:0] OFF_T_TCLK    = 8'h0B;
    localparam logic [7:0] OFF_T_RCLK    = 8'h0C;
    localparam logic [7:0] OFF_T_RDAT    = 8'h0D;
    localparam logic [7:0] OFF_P_CLK     = 8'h10;
    localparam logic [7:0] OFF_P_POS     = 8'h11;
    localparam logic [7:0] OFF_P_NEG     = 8'h12;

    localparam logic [7:0] ID_BOARD  = 8'h0D;
    localparam logic [7:0] ID_XHI    = 8'h00;
    localparam logic [7:0] ID_XMID   = 8'h01;
    localparam logic [7:0] ID_XLO    = 8'h06;

endpackage

// File: rtl/tsx_srcmux.sv
module tsx_srcmux
    import tsx_pkg::*;
#(
    parameter int         NPORT = 16,
    parameter int         SW    = 8,
    parameter path_kind_e KIND  = PATH_CLK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    sel,
    input  logic [NPORT-1:0] port_sig,
    input  logic             osc_t1,
    input  logic             osc_e1,
    input  logic             usr_clk,
    input  logic             aux_a,
    input  logic             aux_b,
    input  logic             tst_clk,
    input  logic             tst_dat,
    output drv_t             drv
);
    localparam int            PW     = $clog2(NPORT);
    localparam logic [SW-1:0] C_NP   = SW'(NPORT);
    localparam logic [SW-1:0] C_T1   = SW'(NPORT);
    localparam logic [SW-1:0] C_E1   = SW'(NPORT + 1);
    localparam logic [SW-1:0] C_USR  = SW'(NPORT + 2);
    localparam logic [SW-1:0] C_AUXA = SW'(NPORT + 3);
    localparam logic [SW-1:0] C_AUXB = SW'(NPORT + 4);
    localparam logic [SW-1:0] C_TST  = SW'(NPORT + 5);
    localparam logic [SW-1:0] C_HIZ0 = SW'(NPORT + 6);

    logic tst_val;

    generate
        if (KIND == PATH_CLK) begin : g_tst_clk
            assign tst_val = tst_clk;
        end else if (KIND == PATH_POS) begin : g_tst_dat
            assign tst_val = tst_dat;
        end else begin : g_tst_zero
            assign tst_val = 1'b0;
        end
    endgenerate

    always_comb begin
        drv = '0;
        if (sel < C_NP) begin
            drv = '{val: port_sig[sel[PW-1:0]], oe: 1'b1};
        end else begin
            case (sel)
                C_T1:    drv = '{val: osc_t1,  oe: 1'b1};
                C_E1:    drv = '{val: osc_e1,  oe: 1'b1};
                C_USR:   drv = '{val: usr_clk, oe: 1'b1};
                C_AUXA:  drv = '{val: aux_a,   oe: 1'b1};
                C_AUXB:  drv = '{val: aux_b,   oe: 1'b1};
                C_TST:   drv = '{val: tst_val, oe: 1'b1};
                default: drv = '0;
            endcase
        end
    end

    // R9: an undriven code never leaves the enable high
    a_r9_hiz_code: assert property (@(posedge clk) disable iff (!rst_n)
        (sel >= C_HIZ0) |-> (!drv.oe && !drv.val));

    generate
        if (KIND == PATH_NEG) begin : g_neg_chk
            // R8: tester code on a negative-data path drives a low level
            a_r8_neg_low: assert property (@(posedge clk) disable iff (!rst_n)
                (sel == C_TST) |-> (drv.oe && !drv.val));
        end
    endgenerate

endmodule

// File: rtl/tsx_regbank.sv
module tsx_regbank
    import tsx_pkg::*;
#(
    parameter int             NPORT     = 16,
    parameter int             AW        = 8,
    parameter int             DW        = 8,
    parameter logic [DW-1:0]  REV_BOARD = 8'h01,
    parameter logic [DW-1:0]  REV_ASSY  = 8'h02,
    parameter logic [DW-1:0]  REV_FW    = 8'h03
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_cs,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [AW-1:0]               bus_addr,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    output logic [DW-1:0]               ctrl_q,
    output logic [DW-1:0]               tsel_tclk,
    output logic [DW-1:0]               tsel_rclk,
    output logic [DW-1:0]               tsel_rdat,
    output logic [NPORT-1:0][DW-1:0]    psel_clk,
    output logic [NPORT-1:0][DW-1:0]    psel_pos,
    output logic [NPORT-1:0][DW-1:0]    psel_neg
);
    localparam int            PW  = $clog2(NPORT);
    localparam logic [DW-1:0] HIZ = '1;
    localparam logic [DW-1:0] NPV = DW'(NPORT);

    bus_st_e       st_q, st_d;
    logic          wr_fire, rd_fire, ptr_ok;
    logic [PW-1:0] pidx;
    logic [DW-1:0] ptr_q, rd_c;

    assign pidx    = ptr_q[PW-1:0];
    assign ptr_ok  = (ptr_q < NPV);
    assign wr_fire = (st_q == BUS_IDLE) && bus_cs && bus_wr;
    assign rd_fire = (st_q == BUS_IDLE) && bus_cs && bus_rd && !bus_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: begin
                if (bus_cs && bus_wr)      st_d = BUS_WR_HOLD;
                else if (bus_cs && bus_rd) st_d = BUS_RD_HOLD;
            end
            BUS_WR_HOLD, BUS_RD_HOLD: begin
                if (!(bus_cs && (bus_wr || bus_rd))) st_d = BUS_IDLE;
            end
            default: st_d = BUS_IDLE;
        endcase
    end

    // read mux
    always_comb begin
        rd_c = '0;
        case (bus_addr)
            AW'(OFF_BOARD_ID):  rd_c = DW'(ID_BOARD);
            AW'(OFF_XID_HI):    rd_c = DW'(ID_XHI);
            AW'(OFF_XID_MID):   rd_c = DW'(ID_XMID);
            AW'(OFF_XID_LO):    rd_c = DW'(ID_XLO);
            AW'(OFF_REV_BOARD): rd_c = REV_BOARD;
            AW'(OFF_REV_ASSY):  rd_c = REV_ASSY;
            AW'(OFF_REV_FW):    rd_c = REV_FW;
            AW'(OFF_CTRL):      rd_c = ctrl_q;
            AW'(OFF_BANK):      rd_c = ptr_q;
            AW'(OFF_T_TCLK):    rd_c = tsel_tclk;
            AW'(OFF_T_RCLK):    rd_c = tsel_rclk;
            AW'(OFF_T_RDAT):    rd_c = tsel_rdat;
            AW'(OFF_P_CLK):     rd_c = ptr_ok ? psel_clk[pidx] : '0;
            AW'(OFF_P_POS):     rd_c = ptr_ok ? psel_pos[pidx] : '0;
            AW'(OFF_P_NEG):     rd_c = ptr_ok ? psel_neg[pidx] : '0;
            default:            rd_c = '0;
        endcase
    end

    // register actions driven by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ptr_q     <= '0;
            tsel_tclk <= HIZ;
            tsel_rclk <= HIZ;
            tsel_rdat <= HIZ;
            psel_clk  <= {NPORT{HIZ}};
            psel_pos  <= {NPORT{HIZ}};
            psel_neg  <= {NPORT{HIZ}};
            bus_rdata <= '0;
        end else begin
            if (rd_fire) bus_rdata <= rd_c;
            if (wr_fire) begin
                case (bus_addr)
                    AW'(OFF_CTRL):   ctrl_q    <= bus_wdata;
                    AW'(OFF_BANK):   ptr_q     <= bus_wdata;
                    AW'(OFF_T_TCLK): tsel_tclk <= bus_wdata;
                    AW'(OFF_T_RCLK): tsel_rclk <= bus_wdata;
                    AW'(OFF_T_RDAT): tsel_rdat <= bus_wdata;
                    AW'(OFF_P_CLK):  if (ptr_ok) psel_clk[pidx] <= bus_wdata;
                    AW'(OFF_P_POS):  if (ptr_ok) psel_pos[pidx] <= bus_wdata;
                    AW'(OFF_P_NEG):  if (ptr_ok) psel_neg[pidx] <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // R4: nothing stored changes while a strobe is being held
    a_r4_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != BUS_IDLE) |=> ($stable(ctrl_q) && $stable(ptr_q) && $stable(psel_clk)
                                && $stable(psel_pos) && $stable(psel_neg) && $stable(tsel_tclk)));

    // R3: writes aimed at read-only offsets are dropped
    a_r3_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && (bus_addr <= AW'(OFF_REV_FW))) |=>
            ($stable(ctrl_q) && $stable(ptr_q) && $stable(tsel_rdat)));

    // R5: an out-of-range bank pointer blocks every indirect write
    a_r5_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && !ptr_ok) |=>
            ($stable(psel_clk) && $stable(psel_pos) && $stable(psel_neg)));

endmodule

// File: rtl/tsx_crosspoint.sv
module tsx_crosspoint
    import tsx_pkg::*;
#(
    parameter int            NPORT     = 16,
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter int            NLED      = 2,
    parameter logic [DW-1:0] REV_BOARD = 8'h01,
    parameter logic [DW-1:0] REV_ASSY  = 8'h02,
    parameter logic [DW-1:0] REV_FW    = 8'h03
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPORT-1:0] rx_clk,
    input  logic [NPORT-1:0] rx_pos,
    input  logic [NPORT-1:0] rx_neg,
    input  logic [NPORT-1:0] rx_los,
    input  logic             osc_t1,
    input  logic             osc_e1,
    input  logic             user_clk,
    input  logic             aux_clk_a,
    input  logic             aux_clk_b,
    input  logic             bert_clk_in,
    input  logic             bert_dat_in,
    output logic [NPORT-1:0] tx_clk,
    output logic [NPORT-1:0] tx_clk_oe,
    output logic [NPORT-1:0] tx_pos,
    output logic [NPORT-1:0] tx_pos_oe,
    output logic [NPORT-1:0] tx_neg,
    output logic [NPORT-1:0] tx_neg_oe,
    output logic             bert_tclk,
    output logic             bert_tclk_oe,
    output logic             bert_rclk,
    output logic             bert_rclk_oe,
    output logic             bert_rdat,
    output logic             bert_rdat_oe,
    output logic             mclk,
    output logic             mclk_oe,
    output logic             liu_mode,
    output logic             liu_clke,
    output logic             liu_bswap,
    output logic             liu_oe,
    output logic [NLED-1:0]  los_led
);
    localparam int CB_MCLK0 = 0;
    localparam int CB_LOE   = 2;
    localparam int CB_SER   = 3;
    localparam int CB_SWAP  = 4;
    localparam int CB_EDGE  = 5;
    localparam int CB_LED0  = DW - NLED;

    logic [DW-1:0]             ctrl_q, tsel_tclk, tsel_rclk, tsel_rdat;
    logic [NPORT-1:0][DW-1:0]  psel_clk, psel_pos, psel_neg;
    drv_t                      d_tclk, d_rclk, d_rdat;

    tsx_regbank #(
        .NPORT(NPORT), .AW(AW), .DW(DW),
        .REV_BOARD(REV_BOARD), .REV_ASSY(REV_ASSY), .REV_FW(REV_FW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_q(ctrl_q),
        .tsel_tclk(tsel_tclk), .tsel_rclk(tsel_rclk), .tsel_rdat(tsel_rdat),
        .psel_clk(psel_clk), .psel_pos(psel_pos), .psel_neg(psel_neg)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            drv_t d_c, d_p, d_n;
            tsx_srcmux #(.NPORT(NPORT), .SW(DW), .KIND(PATH_CLK)) u_clk (
                .clk(clk), .rst_n(rst_n), .sel(psel_clk[p]), .port_sig(rx_clk),
                .osc_t1(osc_t1), .osc_e1(osc_e1), .usr_clk(user_clk),
                .aux_a(aux_clk_a), .aux_b(aux_clk_b),
                .tst_clk(bert_clk_in), .tst_dat(bert_dat_in), .drv(d_c));
            tsx_srcmux #(.NPORT(NPORT), .SW(DW), .KIND(PATH_POS)) u_pos (
                .clk(clk), .rst_n(rst_n), .sel(psel_pos[p]), .port_sig(rx_pos),
                .osc_t1(osc_t1), .osc_e1(osc_e1), .usr_clk(user_clk),
                .aux_a(aux_clk_a), .aux_b(aux_clk_b),
                .tst_clk(bert_clk_in), .tst_dat(bert_dat_in), .drv(d_p));
            tsx_srcmux #(.NPORT(NPORT), .SW(DW), .KIND(PATH_NEG)) u_neg (
                .clk(clk), .rst_n(rst_n), .sel(psel_neg[p]), .port_sig(rx_neg),
                .osc_t1(osc_t1), .osc_e1(osc_e1), .usr_clk(user_clk),
                .aux_a(aux_clk_a), .aux_b(aux_clk_b),
                .tst_clk(bert_clk_in), .tst_dat(bert_dat_in), .drv(d_n));
            assign tx_clk[p]    = d_c.val;
            assign tx_clk_oe[p] = d_c.oe;
            assign tx_pos[p]    = d_p.val;
            assign tx_pos_oe[p] = d_p.oe;
            assign tx_neg[p]    = d_n.val;
            assign tx_neg_oe[p] = d_n.oe;
        end
    endgenerate

    tsx_srcmux #(.NPORT(NPORT), .SW(DW), .KIND(PATH_CLK)) u_bert_tclk (
        .clk(clk), .rst_n(rst_n), .sel(tsel_tclk), .port_sig(rx_clk),
        .osc_t1(osc_t1), .osc_e1(osc_e1), .usr_clk(user_clk),
        .aux_a(aux_clk_a), .aux_b(aux_clk_b),
        .tst_clk(bert_clk_in), .tst_dat(bert_dat_in), .drv(d_tclk));
    tsx_srcmux #(.NPORT(NPORT), .SW(DW), .KIND(PATH_CLK)) u_bert_rclk (
        .clk(clk), .rst_n(rst_n), .sel(tsel_rclk), .port_sig(rx_clk),
        .osc_t1(osc_t1), .osc_e1(osc_e1), .usr_clk(user_clk),
        .aux_a(aux_clk_a), .aux_b(aux_clk_b),
        .tst_clk(bert_clk_in), .tst_dat(bert_dat_in), .drv(d_rclk));
    tsx_srcmux #(.NPORT(NPORT), .SW(DW), .KIND(PATH_POS)) u_bert_rdat (
        .clk(clk), .rst_n(rst_n), .sel(tsel_rdat), .port_sig(rx_pos),
        .osc_t1(osc_t1), .osc_e1(osc_e1), .usr_clk(user_clk),
        .aux_a(aux_clk_a), .aux_b(aux_clk_b),
        .tst_clk(bert_clk_in), .tst_dat(bert_dat_in), .drv(d_rdat));

    assign bert_tclk    = d_tclk.val;
    assign bert_tclk_oe = d_tclk.oe;
    assign bert_rclk    = d_rclk.val;
    assign bert_rclk_oe = d_rclk.oe;
    assign bert_rdat    = d_rdat.val;
    assign bert_rdat_oe = d_rdat.oe;

    // master clock selection
    always_comb begin
        unique case (ctrl_q[CB_MCLK0 +: 2])
            2'b01:   begin mclk = osc_t1;   mclk_oe = 1'b1; end
            2'b10:   begin mclk = osc_e1;   mclk_oe = 1'b1; end
            2'b11:   begin mclk = user_clk; mclk_oe = 1'b1; end
            default: begin mclk = 1'b0;     mclk_oe = 1'b0; end
        endcase
    end

    assign liu_mode  = ~ctrl_q[CB_SER];
    assign liu_clke  = ctrl_q[CB_EDGE] & ctrl_q[CB_SER];
    assign liu_bswap = ctrl_q[CB_SWAP] & ctrl_q[CB_SER];
    assign liu_oe    = ctrl_q[CB_LOE];

    generate
        for (genvar i = 0; i < NLED; i++) begin : g_led
            assign los_led[i] = ctrl_q[CB_LED0 + i] & rx_los[NPORT - NLED + i];
            // R13: a lit LED always has its port's loss flag high
            a_r13_led_needs_los: assert property (@(posedge clk) disable iff (!rst_n)
                los_led[i] |-> rx_los[NPORT - NLED + i]);
        end
    endgenerate

    // R12: the clock-edge and bit-order pins stay low in parallel mode
    a_r12_serial_gating: assert property (@(posedge clk) disable iff (!rst_n)
        (liu_clke || liu_bswap) |-> !liu_mode);

endmodule

// File: tb/tb_tsx_crosspoint.sv
module tb_tsx_crosspoint;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 0, bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [NP-1:0] rx_clk = '0, rx_pos = '0, rx_neg = '0, rx_los = '0;
    logic osc_t1 = 0, osc_e1 = 0, user_clk = 0, aux_clk_a = 0, aux_clk_b = 0;
    logic bert_clk_in = 0, bert_dat_in = 0;
    logic [NP-1:0] tx_clk, tx_clk_oe, tx_pos, tx_pos_oe, tx_neg, tx_neg_oe;
    logic bert_tclk, bert_tclk_oe, bert_rclk, bert_rclk_oe, bert_rdat, bert_rdat_oe;
    logic mclk, mclk_oe, liu_mode, liu_clke, liu_bswap, liu_oe;
    logic [1:0] los_led;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsx_crosspoint dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_clk(rx_clk), .rx_pos(rx_pos), .rx_neg(rx_neg), .rx_los(rx_los),
        .osc_t1(osc_t1), .osc_e1(osc_e1), .user_clk(user_clk),
        .aux_clk_a(aux_clk_a), .aux_clk_b(aux_clk_b),
        .bert_clk_in(bert_clk_in), .bert_dat_in(bert_dat_in),
        .tx_clk(tx_clk), .tx_clk_oe(tx_clk_oe), .tx_pos(tx_pos), .tx_pos_oe(tx_pos_oe),
        .tx_neg(tx_neg), .tx_neg_oe(tx_neg_oe),
        .bert_tclk(bert_tclk), .bert_tclk_oe(bert_tclk_oe),
        .bert_rclk(bert_rclk), .bert_rclk_oe(bert_rclk_oe),
        .bert_rdat(bert_rdat), .bert_rdat_oe(bert_rdat_oe),
        .mclk(mclk), .mclk_oe(mclk_oe), .liu_mode(liu_mode), .liu_clke(liu_clke),
        .liu_bswap(liu_bswap), .liu_oe(liu_oe), .los_led(los_led)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares each read result with the queued expectation
    always begin
        @(rd_done);
        chk(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_cs = 1; bus_rd = 1; bus_addr = a;
        @(posedge clk);
        #1 -> rd_done;
        @(negedge clk);
        bus_cs = 0; bus_rd = 0;
    endtask

    task automatic apply_pat(input bit inv);
        rx_clk = inv ? ~16'hA5C3 : 16'hA5C3;
        rx_pos = inv ? ~16'h3C96 : 16'h3C96;
        rx_neg = inv ? ~16'h0FF0 : 16'h0FF0;
        osc_t1 = ~inv; osc_e1 = inv; user_clk = ~inv; aux_clk_a = inv;
        aux_clk_b = ~inv; bert_clk_in = inv; bert_dat_in = ~inv;
        #1;
    endtask

    // expected {value, enable} from the source code rules
    function automatic logic [1:0] model(input int kind, input int code, input logic [NP-1:0] pv);
        if (code < 16)  return {pv[code], 1'b1};
        case (code)
            16: return {osc_t1, 1'b1};
            17: return {osc_e1, 1'b1};
            18: return {user_clk, 1'b1};
            19: return {aux_clk_a, 1'b1};
            20: return {aux_clk_b, 1'b1};
            21: return (kind == 0) ? {bert_clk_in, 1'b1} :
                       (kind == 1) ? {bert_dat_in, 1'b1} : 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic string code_tag(input int code);
        if (code < 16)  return "R6";
        if (code < 21)  return "R7";
        if (code == 21) return "R8";
        return "R9";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int codes[11] = '{0, 5, 15, 16, 17, 18, 19, 20, 21, 22, 255};
        int ports[3]  = '{0, 3, 15};
        rx_los = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_clk_oe", tx_clk_oe, 0);
        chk("R1 tx_pos_oe", tx_pos_oe, 0);
        chk("R1 tx_neg_oe", tx_neg_oe, 0);
        chk("R1 bert oe", {bert_tclk_oe, bert_rclk_oe, bert_rdat_oe}, 0);
        chk("R1 mclk_oe", mclk_oe, 0);
        chk("R1 pins", {liu_mode, liu_clke, liu_bswap, liu_oe}, 4'b1000);
        chk("R1 los_led", los_led, 0);
        chk("R1 rdata", bus_rdata, 0);
        bus_read(8'h0A, 8'h00, "R1 bank");
        bus_read(8'h08, 8'h00, "R1 ctrl");
        bus_read(8'h10, 8'hFF, "R1 port clk code");

        // R2 identity and revisions
        bus_read(8'h00, 8'h0D, "R2 id0");
        bus_read(8'h02, 8'h00, "R2 id2");
        bus_read(8'h03, 8'h01, "R2 id3");
        bus_read(8'h04, 8'h06, "R2 id4");
        bus_read(8'h05, 8'h01, "R2 rev5");
        bus_read(8'h06, 8'h02, "R2 rev6");
        bus_read(8'h07, 8'h03, "R2 rev7");

        // R3 read-only and unmapped offsets
        bus_write(8'h00, 8'h55);
        bus_read(8'h00, 8'h0D, "R3 ro write");
        bus_write(8'h09, 8'hAA);
        bus_read(8'h09, 8'h00, "R3 unmapped 09");
        bus_read(8'h01, 8'h00, "R3 unmapped 01");
        bus_read(8'h20, 8'h00, "R3 unmapped 20");
        bus_read(8'h08, 8'h00, "R3 ctrl untouched");
        bus_read(8'h0A, 8'h00, "R3 bank untouched");

        // R4 held write strobe writes once with first-edge data
        @(negedge clk);
        bus_cs = 1; bus_wr = 1; bus_addr = 8'h0A; bus_wdata = 8'h05;
        @(negedge clk);
        bus_wdata = 8'h09;
        @(negedge clk);
        @(negedge clk);
        bus_cs = 0; bus_wr = 0;
        bus_read(8'h0A, 8'h05, "R4 single write");
        @(negedge clk);
        bus_addr = 8'h00;
        @(negedge clk);
        chk("R4 rdata holds", bus_rdata, 8'h05);

        // R5..R9 indirect routing per port
        foreach (ports[pi]) begin
            int p = ports[pi];
            bus_write(8'h0A, p[7:0]);
            foreach (codes[ci]) begin
                int c = codes[ci];
                for (int k = 0; k < 3; k++) begin
                    bus_write(8'h10 + k[7:0], c[7:0]);
                    bus_read(8'h10 + k[7:0], c[7:0], "R5 readback");
                    for (int inv = 0; inv < 2; inv++) begin
                        logic [1:0] e;
                        logic [1:0] a;
                        apply_pat(inv[0]);
                        if (k == 0) begin
                            e = model(0, c, rx_clk); a = {tx_clk[p], tx_clk_oe[p]};
                        end else if (k == 1) begin
                            e = model(1, c, rx_pos); a = {tx_pos[p], tx_pos_oe[p]};
                        end else begin
                            e = model(2, c, rx_neg); a = {tx_neg[p], tx_neg_oe[p]};
                        end
                        chk(code_tag(c), a, e);
                    end
                end
            end
        end
        // R5 untouched port stays undriven
        chk("R5 port7 isolated", {tx_clk_oe[7], tx_pos_oe[7], tx_neg_oe[7]}, 0);

        // R5 out-of-range bank pointer
        bus_write(8'h0A, 8'h20);
        bus_write(8'h10, 8'h03);
        bus_read(8'h10, 8'h00, "R5 oob read");
        bus_write(8'h0A, 8'h07);
        bus_read(8'h10, 8'hFF, "R5 oob write dropped");
        chk("R5 oob no drive", tx_clk_oe[7], 0);

        // R10 tester source selects
        foreach (codes[ci]) begin
            int c = codes[ci];
            bus_write(8'h0B, c[7:0]);
            bus_write(8'h0C, c[7:0]);
            bus_write(8'h0D, c[7:0]);
            bus_read(8'h0D, c[7:0], "R10 readback");
            for (int inv = 0; inv < 2; inv++) begin
                apply_pat(inv[0]);
                chk("R10 tclk", {bert_tclk, bert_tclk_oe}, model(0, c, rx_clk));
                chk("R10 rclk", {bert_rclk, bert_rclk_oe}, model(0, c, rx_clk));
                chk("R10 rdat", {bert_rdat, bert_rdat_oe}, model(1, c, rx_pos));
            end
        end

        // R11 master clock
        for (int m = 0; m < 4; m++) begin
            bus_write(8'h08, m[7:0]);
            for (int inv = 0; inv < 2; inv++) begin
                apply_pat(inv[0]);
                case (m)
                    0: chk("R11 mclk hiz", mclk_oe, 0);
                    1: chk("R11 mclk t1", {mclk, mclk_oe}, {osc_t1, 1'b1});
                    2: chk("R11 mclk e1", {mclk, mclk_oe}, {osc_e1, 1'b1});
                    default: chk("R11 mclk usr", {mclk, mclk_oe}, {user_clk, 1'b1});
                endcase
            end
        end

        // R12 mode and serial-gated pins
        bus_write(8'h08, 8'h38);
        chk("R12 serial", {liu_mode, liu_clke, liu_bswap, liu_oe}, 4'b0110);
        bus_write(8'h08, 8'h30);
        chk("R12 parallel gating", {liu_mode, liu_clke, liu_bswap, liu_oe}, 4'b1000);
        bus_write(8'h08, 8'h04);
        chk("R12 liu_oe", {liu_mode, liu_oe}, 2'b11);
        bus_read(8'h08, 8'h04, "R12 ctrl readback");

        // R13 LED gating
        rx_los = 16'h8000;
        bus_write(8'h08, 8'hC0);
        chk("R13 led16 only", los_led, 2'b10);
        rx_los = 16'h4000;
        #1;
        chk("R13 led15 only", los_led, 2'b01);
        rx_los = 16'hC000;
        bus_write(8'h08, 8'h40);
        chk("R13 enable gates", los_led, 2'b01);
        bus_write(8'h08, 8'h00);
        chk("R13 disabled", los_led, 2'b00);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule